// File: doc/BRIEF.md
# PCI Type-0 Configuration Address Translator

This block sits behind a host bridge's downstream configuration window. A processor access that lands in the window carries only 16 meaningful address bits. A map register supplies the 16 bits above them. Together they form a 32-bit composed address. The upper part of that address holds a one-hot device-select field. The block finds the lowest select line that is set and turns its position into a binary device number. It then packs that number, with the function and register fields and the local bus number, into a standard configuration address with the enable bit set.

Three conditions stop a translation. The first is a map register that asks for a cycle other than type 0. The second is a select field with no bit set. The third is a half-word or word access that is not naturally aligned. When any of these holds, the result is marked not usable, and the all-ones read value for the access size is offered instead. Each request is qualified by a strobe, and its result appears one clock later on registered outputs.

Top module: `cfg_type0_xlate`

## Requirements
- R1: `out_stb` is high exactly in the cycle after a cycle with `req_valid` high. `out_ok` and all three fault flags are low in any cycle where `out_stb` is low.
- R2: When map bit 16 (`map_cfg[16]`) is set, the result has `out_type_bad` high and `out_ok` low, and `out_idsel_err` stays low.
- R3: The composed address is `{map_cfg[15:0], req_addr[15:0]}`. Its bits [31:11] form the select field, and the device number is the index of the lowest set bit of that field (select bit k gives device k).
- R4: The function number is composed bits [10:8]. The register number is composed bits [7:2], and it stays at that same byte position in the output.
- R5: A usable result is packed as bit 31 = 1, bits [30:24] = 0, bus [23:16], device [15:11], function [10:8], register [7:2], bits [1:0] = 0.
- R6: A select field of all zeros, with map bit 16 clear, raises `out_idsel_err` and gives `out_cfg_addr` = 0.
- R7: `req_size` encodes 0 = byte, 1 = half-word, 2 = word, and 3 = word. A half-word access with `req_addr[0]` = 1 faults. A word access with `req_addr[1:0]` ≠ 0 faults. A byte access never faults. A fault raises `out_align_err`.
- R8: `out_ok` is high for a result exactly when none of `out_type_bad`, `out_idsel_err` or `out_align_err` is high.
- R9: `out_fill` is 0x000000FF, 0x0000FFFF or 0xFFFFFFFF for a byte, half-word or word result that is not usable. It is 0 for a usable result. `out_cfg_addr` is 0 for a result that is not usable.
- R10: While `rst_n` is low at a clock edge, every output is cleared to 0 at that edge.
- R11: When several select bits are set, the lowest one alone decides the device number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A request is presented this cycle |
| req_addr | input | 16 | Low address bits of the access |
| map_cfg | input | 17 | Map register bits [16:0]: upper composed bits and the not-type-0 bit |
| req_size | input | 2 | Access size code (0 byte, 1 half, 2 or 3 word) |
| bus_num | input | 8 | Local bus number placed in the output |
| out_stb | output | 1 | A result is presented this cycle |
| out_ok | output | 1 | The result is a usable configuration address |
| out_cfg_addr | output | 32 | Packed configuration address, enable bit included |
| out_type_bad | output | 1 | The map register asked for a cycle other than type 0 |
| out_idsel_err | output | 1 | No device-select bit was set |
| out_align_err | output | 1 | The access was misaligned for its size |
| out_fill | output | 32 | All-ones read value for the size when the result is not usable |

## Verification
The bench uses the default parameters: 16 access bits and 16 map bits. This gives a 21-bit select field with device numbers 0 to 20. Five select lines come from the access address and sixteen come from the map register. A directed sweep drives each of the 21 positions on its own, so the encoder's edges and the seam between the two sources are both reached. Multi-bit and empty select fields, the not-type-0 bit, and misaligned half-word and word accesses are covered directly. Random requests mix all sizes and bus numbers.

// File: rtl/cfgx_pkg.sv
// Shared types and fixed field positions for the configuration address translator.
// Assumes the standard type-0 layout: select field starts at composed bit 11.
package cfgx_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WIDE = 2'd3
    } acc_size_e;

    localparam int SEL_LSB   = 11;  // first select line in the composed address
    localparam int FUNC_W    = 3;
    localparam int REGN_W    = 6;
    localparam int DEVF_W    = 5;   // device field width in the output
    localparam int BUSF_W    = 8;   // bus field width in the output
    localparam int OUT_W     = 32;

    typedef struct packed {
        logic [DEVF_W-1:0] dev;
        logic [FUNC_W-1:0] func;
        logic [REGN_W-1:0] regn;
    } cfg_fields_t;
endpackage

// File: rtl/cfgx_lowbit.sv
// Lowest-set-bit priority encoder.
// Produces the index of the least significant set bit of vec and a flag telling
// whether any bit is set. When no bit is set, idx is 0.
module cfgx_lowbit #(
    parameter int W     = 21,
    localparam int IDX_W = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]     vec,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    logic [W-1:0] seen;   // bit i: some bit at or below i is set
    logic [W-1:0] first;  // one-hot marker of the lowest set bit

    assign seen[0]  = vec[0];
    assign first[0] = vec[0];

    genvar gi;
    generate
        for (gi = 1; gi < W; gi++) begin : g_chain
            assign seen[gi]  = seen[gi-1] | vec[gi];
            assign first[gi] = vec[gi] & ~seen[gi-1];
        end
    endgenerate

    assign any = seen[W-1];

    // Turn the one-hot marker into a binary index.
    always_comb begin
        idx = '0;
        for (int i = 0; i < W; i++) begin
            if (first[i]) idx = idx | IDX_W'(i);
        end
    end
endmodule

// File: rtl/cfgx_align.sv
// Alignment checker and all-ones fill generator.
// Assumes size code 3 behaves as a word. The fill is the all-ones read value
// for the access width; the caller decides when to use it.
module cfgx_align
    import cfgx_pkg::*;
(
    input  logic [1:0]       size,
    input  logic [1:0]       addr_lo,
    output logic             fault,
    output logic [OUT_W-1:0] fill
);
    // Decode the size into a fault and a fill pattern.
    always_comb begin
        case (acc_size_e'(size))
            SZ_BYTE: begin
                fault = 1'b0;
                fill  = 32'h0000_00FF;
            end
            SZ_HALF: begin
                fault = addr_lo[0];
                fill  = 32'h0000_FFFF;
            end
            default: begin
                fault = |addr_lo;
                fill  = 32'hFFFF_FFFF;
            end
        endcase
    end
endmodule

// File: rtl/cfgx_fields.sv
// Field extractor: builds the select vector from the map bits above the access
// bits and takes the function and register numbers from the access address.
// Assumes ADDR_W > SEL_LSB so that the access supplies the low select lines.
module cfgx_fields
    import cfgx_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int MAP_W  = 16,
    localparam int SEL_W = ADDR_W + MAP_W - SEL_LSB
) (
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [MAP_W-1:0]  map_lo,
    output logic [SEL_W-1:0]  sel_vec,
    output logic [FUNC_W-1:0] func,
    output logic [REGN_W-1:0] regn
);
    assign sel_vec = {map_lo, acc_addr[ADDR_W-1:SEL_LSB]};
    assign func    = acc_addr[SEL_LSB-1 -: FUNC_W];
    assign regn    = acc_addr[SEL_LSB-FUNC_W-1 -: REGN_W];
endmodule

// File: rtl/cfg_type0_xlate.sv
// Type-0 configuration address translator, top level.
// Combinational translation of the access address and map bits, followed by one
// registered output stage loaded when req_valid is high. Flags and out_ok are
// strobe-qualified; address and fill hold their last loaded value.
// Assumes map_cfg[MAP_W] is the not-type-0 bit and bus_num fits the bus field.
module cfg_type0_xlate
    import cfgx_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int MAP_W  = 16,
    parameter int BUS_W  = 8,
    localparam int SEL_W = ADDR_W + MAP_W - SEL_LSB,
    localparam int IDX_W = $clog2(SEL_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [MAP_W:0]    map_cfg,
    input  logic [1:0]        req_size,
    input  logic [BUS_W-1:0]  bus_num,
    output logic              out_stb,
    output logic              out_ok,
    output logic [OUT_W-1:0]  out_cfg_addr,
    output logic              out_type_bad,
    output logic              out_idsel_err,
    output logic              out_align_err,
    output logic [OUT_W-1:0]  out_fill
);
    logic [SEL_W-1:0]  sel_vec;
    logic [FUNC_W-1:0] func;
    logic [REGN_W-1:0] regn;
    logic              sel_any;
    logic [IDX_W-1:0]  dev_idx;
    logic              mis_c;
    logic [OUT_W-1:0]  fill_mask;
    logic              type_bad_c, sel_err_c, ok_c;
    cfg_fields_t       flds;
    logic [OUT_W-1:0]  addr_c, fill_c;

    cfgx_fields #(.ADDR_W(ADDR_W), .MAP_W(MAP_W)) u_fields (
        .acc_addr (req_addr),
        .map_lo   (map_cfg[MAP_W-1:0]),
        .sel_vec  (sel_vec),
        .func     (func),
        .regn     (regn)
    );

    cfgx_lowbit #(.W(SEL_W)) u_lowbit (
        .vec (sel_vec),
        .any (sel_any),
        .idx (dev_idx)
    );

    cfgx_align u_align (
        .size    (req_size),
        .addr_lo (req_addr[1:0]),
        .fault   (mis_c),
        .fill    (fill_mask)
    );

    // Classify the request and pack the configuration address.
    always_comb begin
        type_bad_c = map_cfg[MAP_W];
        sel_err_c  = !type_bad_c && !sel_any;
        ok_c       = !type_bad_c && !sel_err_c && !mis_c;
        flds.dev   = DEVF_W'(dev_idx);
        flds.func  = func;
        flds.regn  = regn;
        addr_c     = ok_c ? {1'b1, 7'd0, BUSF_W'(bus_num), flds, 2'b00} : '0;
        fill_c     = ok_c ? '0 : fill_mask;
    end

    // Output stage: strobe and flags follow req_valid; data loads on a request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_stb       <= 1'b0;
            out_ok        <= 1'b0;
            out_type_bad  <= 1'b0;
            out_idsel_err <= 1'b0;
            out_align_err <= 1'b0;
            out_cfg_addr  <= '0;
            out_fill      <= '0;
        end else begin
            out_stb       <= req_valid;
            out_ok        <= req_valid && ok_c;
            out_type_bad  <= req_valid && type_bad_c;
            out_idsel_err <= req_valid && sel_err_c;
            out_align_err <= req_valid && mis_c;
            if (req_valid) begin
                out_cfg_addr <= addr_c;
                out_fill     <= fill_c;
            end
        end
    end
endmodule

// File: rtl/cfgx_checker.sv
// Property checker for the configuration address translator, bound to the top.
module cfgx_checker #(
    parameter int ADDR_W = 16,
    parameter int MAP_W  = 16,
    parameter int BUS_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic [MAP_W:0]    map_cfg,
    input logic [1:0]        req_size,
    input logic [BUS_W-1:0]  bus_num,
    input logic              out_stb,
    input logic              out_ok,
    input logic [31:0]       out_cfg_addr,
    input logic              out_type_bad,
    input logic              out_idsel_err,
    input logic              out_align_err,
    input logic [31:0]       out_fill
);
    p_stb_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_stb);
    p_stb_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !out_stb);
    p_quiet_flags_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !out_stb |-> !out_ok && !out_type_bad && !out_idsel_err && !out_align_err);
    p_type_bad_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && map_cfg[MAP_W] |=> out_type_bad && !out_ok && !out_idsel_err);
    p_pack_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_ok |-> out_cfg_addr[31] && out_cfg_addr[30:24] == 7'd0 && out_cfg_addr[1:0] == 2'd0);
    p_empty_sel_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !map_cfg[MAP_W] && map_cfg[MAP_W-1:0] == '0 && req_addr[ADDR_W-1:11] == '0
        |=> out_idsel_err && out_cfg_addr == 32'd0);
    p_byte_aligned_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_size == 2'd0 |=> !out_align_err);
    p_ok_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_stb |-> out_ok == !(out_type_bad || out_idsel_err || out_align_err));
    p_fill_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_ok |-> out_fill == 32'd0);
    p_reset_clear_r10: assert property (@(posedge clk)
        !rst_n |=> !out_stb && !out_ok && out_cfg_addr == 32'd0 && out_fill == 32'd0);
endmodule

bind cfg_type0_xlate cfgx_checker #(.ADDR_W(ADDR_W), .MAP_W(MAP_W), .BUS_W(BUS_W)) u_cfgx_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_addr      (req_addr),
    .map_cfg       (map_cfg),
    .req_size      (req_size),
    .bus_num       (bus_num),
    .out_stb       (out_stb),
    .out_ok        (out_ok),
    .out_cfg_addr  (out_cfg_addr),
    .out_type_bad  (out_type_bad),
    .out_idsel_err (out_idsel_err),
    .out_align_err (out_align_err),
    .out_fill      (out_fill)
);

// File: tb/test_cfg_type0_xlate.sv
module test_cfg_type0_xlate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_addr = '0;
    logic [16:0] map_cfg = '0;
    logic [1:0]  req_size = '0;
    logic [7:0]  bus_num = '0;
    logic        out_stb, out_ok, out_type_bad, out_idsel_err, out_align_err;
    logic [31:0] out_cfg_addr, out_fill;
    int          n_chk = 0;
    int          n_fail = 0;

    always #5 clk = ~clk;

    cfg_type0_xlate i_cfg_type0_xlate (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .map_cfg(map_cfg), .req_size(req_size), .bus_num(bus_num),
        .out_stb(out_stb), .out_ok(out_ok), .out_cfg_addr(out_cfg_addr),
        .out_type_bad(out_type_bad), .out_idsel_err(out_idsel_err),
        .out_align_err(out_align_err), .out_fill(out_fill)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Expected result computed from the requirements.
    task automatic model(input logic [15:0] a, input logic [16:0] m, input logic [1:0] sz,
                         input logic [7:0] b, output logic e_ok, output logic e_tb,
                         output logic e_ie, output logic e_ae,
                         output logic [31:0] e_addr, output logic [31:0] e_fill);
        logic [31:0] comp;
        logic [20:0] sel;
        int          dev;
        comp = {m[15:0], a};
        sel  = comp[31:11];
        dev  = 0;
        for (int i = 20; i >= 0; i--) if (sel[i]) dev = i;
        e_tb = m[16];
        e_ie = !e_tb && (sel == 21'd0);
        e_ae = (sz == 2'd1 && a[0]) || (sz >= 2'd2 && a[1:0] != 2'd0);
        e_ok = !e_tb && !e_ie && !e_ae;
        e_addr = e_ok ? (32'h8000_0000 | (32'(b) << 16) | (32'(dev) << 11)
                         | (32'(comp[10:8]) << 8) | {24'd0, comp[7:2], 2'b00}) : 32'd0;
        e_fill = e_ok ? 32'd0 : (sz == 2'd0 ? 32'hFF : (sz == 2'd1 ? 32'hFFFF : 32'hFFFF_FFFF));
    endtask

    task automatic do_req(input string tag, input logic [15:0] a, input logic [16:0] m,
                          input logic [1:0] sz, input logic [7:0] b);
        logic e_ok, e_tb, e_ie, e_ae;
        logic [31:0] e_addr, e_fill;
        model(a, m, sz, b, e_ok, e_tb, e_ie, e_ae, e_addr, e_fill);
        @(negedge clk);
        req_addr = a; map_cfg = m; req_size = sz; bus_num = b; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R1", "strobe", 32'(out_stb), 32'd1);
        chk("R8", "ok", 32'(out_ok), 32'(e_ok));
        chk("R2", "type_bad", 32'(out_type_bad), 32'(e_tb));
        chk("R6", "idsel_err", 32'(out_idsel_err), 32'(e_ie));
        chk("R7", "align_err", 32'(out_align_err), 32'(e_ae));
        chk(tag, "cfg_addr", out_cfg_addr, e_addr);
        chk("R9", "fill", out_fill, e_fill);
        @(negedge clk);
        chk("R1", "idle strobe", 32'(out_stb), 32'd0);
        chk("R1", "idle ok", 32'(out_ok), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10", "stb", 32'(out_stb), 32'd0);
        chk("R10", "ok", 32'(out_ok), 32'd0);
        chk("R10", "addr", out_cfg_addr, 32'd0);
        chk("R10", "fill", out_fill, 32'd0);
        chk("R10", "flags", {29'd0, out_type_bad, out_idsel_err, out_align_err}, 32'd0);
        rst_n = 1'b1;
        // R3: each select line alone, both sources
        for (int k = 0; k < 21; k++) begin
            logic [31:0] comp;
            comp = (32'd1 << (k + 11)) | 32'h0000_05A4;
            do_req("R3", comp[15:0], {1'b0, comp[31:16]}, 2'd2, 8'(k * 11));
        end
        // R4: function and register fields
        do_req("R4", 16'h0F04 | 16'h0800, 17'h0, 2'd2, 8'h3C);
        do_req("R4", 16'h08FC, 17'h0, 2'd0, 8'h01);
        // R5: packing with maximal bus number
        do_req("R5", 16'h8000, 17'h0, 2'd2, 8'hFF);
        // R11: several select bits, lowest wins
        do_req("R11", 16'hF800, 17'h0FFFF, 2'd2, 8'h00);
        do_req("R11", 16'h0000, 17'h0A0A, 2'd1, 8'h42);
        do_req("R11", 16'h1000, 17'h08000, 2'd0, 8'h07);
        // R6: empty select field
        do_req("R6", 16'h07FC, 17'h0, 2'd2, 8'h11);
        // R2: not type 0, each size
        do_req("R2", 16'h0800, 17'h10000, 2'd0, 8'h00);
        do_req("R2", 16'h0800, 17'h10000, 2'd1, 8'h00);
        do_req("R2", 16'h0000, 17'h10000, 2'd2, 8'h00);
        // R7: alignment corners
        do_req("R7", 16'h0801, 17'h0, 2'd1, 8'h00);
        do_req("R7", 16'h0802, 17'h0, 2'd1, 8'h00);
        do_req("R7", 16'h0802, 17'h0, 2'd2, 8'h00);
        do_req("R7", 16'h0801, 17'h0, 2'd3, 8'h00);
        do_req("R7", 16'h0803, 17'h0, 2'd0, 8'h00);
        // Random mix
        for (int n = 0; n < 400; n++) begin
            logic [15:0] a;
            logic [16:0] m;
            a = 16'($urandom);
            m = 17'($urandom);
            m[16] = ($urandom_range(0, 7) == 0);
            if ($urandom_range(0, 9) == 0) begin
                m[15:0] = 16'd0;
                a[15:11] = 5'd0;
            end
            do_req("R3", a, m, 2'($urandom), 8'($urandom));
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule